// File: doc/BRIEF.md
# Two-Wire Bus Slave for Clock and RAM Registers

This block is the bus-facing front end of a battery-backed timekeeper. It listens on a two-wire serial bus at standard-mode rates. It answers the fixed 7-bit device address 1101000 and gives a bus master byte access to a 64-location space. Locations 00h–07h are the eight timekeeping registers, which belong to the clock core. Locations 08h–3Fh are 56 bytes of general-purpose RAM, held inside the block. Both bus lines are brought in as raw levels and resampled on the system clock. The block answers only by enabling an open-drain pull-down on the data line.

A write transfer sets the internal location pointer with its first data byte. Each byte after that lands at the pointer, and the pointer then advances, wrapping from the top of the space back to zero. Writes that fall on the clock registers are passed to the clock core through a one-cycle write strobe. A read transfer streams bytes from the pointer onward. Clock-register bytes are served from a copy of the live time taken at every START, so a multi-byte read is coherent while the core keeps counting. A power-fail input stops any transfer in progress, zeroes the pointer and shuts the block off the bus for as long as it is held.

Top module: `rtc_bus_slave`

## Requirements
- R1: After reset the data-line pull-down (`sdaOe`) is off and no clock-core write strobe (`coreWrEn`) is issued.
- R2: An address byte of 1101000 followed by a direction bit is acknowledged (data line pulled low in the ninth clock); direction bit 0 selects a write transfer and 1 selects a read transfer. Any other address is not acknowledged, and the block leaves the bus alone (no acknowledge, no writes, pointer unchanged) until the next START.
- R3: In a write transfer, the first byte after the address loads the pointer with its low 6 bits (bits 7:6 are ignored). Each later byte is stored at the pointer, which then advances by one. Every one of these bytes is acknowledged, and each stored byte gives exactly one write, never two in a row.
- R4: In a read transfer, bytes are sent most-significant bit first, starting at the pointer. The pointer advances after each byte, and bytes keep coming while the master acknowledges. After a master not-acknowledge the data line is released and stays released until the next START.
- R5: A read transfer that is not preceded by a pointer write starts at the retained pointer: one past the last location written or read.
- R6: The pointer wraps from 3Fh to 00h during multi-byte reads and writes.
- R7: A byte written at 00h–07h is forwarded on `coreWrAddr`/`coreWrData`, with one `coreWrEn` pulse, and not kept locally. A byte written at 08h–3Fh is stored in the internal RAM and produces no `coreWrEn`.
- R8: Reads of 00h–07h return the value `liveTime` held when the most recent START (including a repeated START) was seen. Changes of `liveTime` after that START do not appear until the next one.
- R9: A repeated START ends the current transfer and begins a new address phase without a STOP, so a pointer write followed by a repeated START and a read address reads from the new pointer.
- R10: While `pwrFail` is high, the pull-down is released from the next cycle on, no write strobe or RAM write occurs, the pointer is forced to 00h, and no bus byte is acknowledged.
- R11: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level (asynchronous) |
| sdaIn | input | 1 | Bus data line level (asynchronous) |
| pwrFail | input | 1 | High while the main supply is below the power-fail threshold (synchronous to clk) |
| liveTime | input | 64 | Running clock registers from the core; byte i at bits 8i+7:8i |
| sdaOe | output | 1 | When high, the data line is pulled low |
| coreWrEn | output | 1 | One-cycle strobe writing a clock register in the core |
| coreWrAddr | output | 3 | Clock register selected by the strobe |
| coreWrData | output | 8 | Byte written by the strobe |

## Verification
The checks assume that each SCL low and high phase lasts well beyond the three system-clock cycles that the synchronisers and edge detection add. They also assume that the master changes SDA only inside the low phase, clear of the SCL edges, and that `pwrFail` is synchronous to the system clock. The bench's master model divides every bus bit into four phases of eight system clocks and moves SDA only at the first of them, in mid-low. When it needs a repeated START or a STOP, it raises or lowers SDA only while SCL is low and the slave has released the line.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_SKIP
  } busState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       snap;
    logic       loadPtr;
    logic       wrByte;
    logic       incPtr;
    logic       clrPtr;
    logic [7:0] byteVal;
  } strobe_t;

endpackage

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1101000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       pwrFail,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output strobe_t    stb
);

  localparam int SYNC_W = 3;
  localparam logic [3:0] LAST_RX = 4'd8;
  localparam logic [3:0] LAST_TX = 4'd7;

  logic [SYNC_W-1:0] sclPipe, sdaPipe;
  logic sclRise, sclFall, startDet, stopDet, sdaNow;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] rxSh, txSh;
  logic       inAddr, isRead, havePtr, mNak;

  assign sdaNow   = sdaPipe[1];
  assign sclRise  = sclPipe[1] & ~sclPipe[2];
  assign sclFall  = ~sclPipe[1] & sclPipe[2];
  assign startDet = sclPipe[1] & sclPipe[2] & sdaPipe[2] & ~sdaPipe[1];
  assign stopDet  = sclPipe[1] & sclPipe[2] & ~sdaPipe[2] & sdaPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rxSh    <= '0;
      txSh    <= '0;
      inAddr  <= 1'b0;
      isRead  <= 1'b0;
      havePtr <= 1'b0;
      mNak    <= 1'b0;
      sdaOe   <= 1'b0;
      stb     <= '0;
    end else begin
      sclPipe <= {sclPipe[SYNC_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_W-2:0], sdaIn};
      stb     <= '0;
      if (pwrFail) begin
        state       <= ST_IDLE;
        sdaOe       <= 1'b0;
        stb.clrPtr  <= 1'b1;
      end else if (startDet) begin
        state    <= ST_RECV;
        inAddr   <= 1'b1;
        bitCnt   <= '0;
        sdaOe    <= 1'b0;
        stb.snap <= 1'b1;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_RECV: begin
            if (sclRise && bitCnt != LAST_RX) begin
              rxSh   <= {rxSh[6:0], sdaNow};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == LAST_RX) begin
              bitCnt <= '0;
              inAddr <= 1'b0;
              if (inAddr) begin
                if (rxSh[7:1] == SLAVE_ADDR) begin
                  sdaOe   <= 1'b1;
                  state   <= ST_ACK;
                  isRead  <= rxSh[0];
                  havePtr <= 1'b0;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                sdaOe       <= 1'b1;
                state       <= ST_ACK;
                stb.byteVal <= rxSh;
                if (havePtr) begin
                  stb.wrByte <= 1'b1;
                end else begin
                  stb.loadPtr <= 1'b1;
                  havePtr     <= 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                txSh  <= rdByte;
                sdaOe <= ~rdByte[7];
                state <= ST_SEND;
              end else begin
                sdaOe <= 1'b0;
                state <= ST_RECV;
              end
            end
          end
          ST_SEND: begin
            if (sclFall) begin
              if (bitCnt == LAST_TX) begin
                sdaOe      <= 1'b0;
                state      <= ST_MACK;
                stb.incPtr <= 1'b1;
                bitCnt     <= '0;
              end else begin
                txSh   <= {txSh[6:0], 1'b0};
                sdaOe  <= ~txSh[6];
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (sclRise) begin
              mNak <= sdaNow;
            end else if (sclFall) begin
              if (mNak) begin
                state <= ST_SKIP;
              end else begin
                txSh   <= rdByte;
                sdaOe  <= ~rdByte[7];
                state  <= ST_SEND;
                bitCnt <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cs_data.sv
module i2cs_data
  import i2cs_pkg::*;
#(
  parameter int SPACE     = 64,
  parameter int TIME_REGS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pwrFail,
  input  strobe_t                      stb,
  input  logic [TIME_REGS*8-1:0]       liveTime,
  output logic [7:0]                   rdByte,
  output logic                         coreWrEn,
  output logic [$clog2(TIME_REGS)-1:0] coreWrAddr,
  output logic [7:0]                   coreWrData
);

  localparam int PTR_W     = $clog2(SPACE);
  localparam int T_W       = $clog2(TIME_REGS);
  localparam int RAM_DEPTH = SPACE - TIME_REGS;

  logic [PTR_W-1:0] ptr, ptrNext, ramIdx;
  logic             inTime;
  logic [7:0]       shadow [TIME_REGS];
  logic [7:0]       ram    [RAM_DEPTH];

  assign inTime  = ptr < PTR_W'(TIME_REGS);
  assign ramIdx  = ptr - PTR_W'(TIME_REGS);
  assign ptrNext = (ptr == PTR_W'(SPACE - 1)) ? '0 : ptr + PTR_W'(1);
  assign rdByte  = inTime ? shadow[ptr[T_W-1:0]] : ram[ramIdx];

  always_ff @(posedge clk) begin
    if (!rstN || pwrFail || stb.clrPtr) begin
      ptr <= '0;
    end else if (stb.loadPtr) begin
      ptr <= stb.byteVal[PTR_W-1:0];
    end else if (stb.wrByte || stb.incPtr) begin
      ptr <= ptrNext;
    end
  end

  for (genvar g = 0; g < TIME_REGS; g++) begin : gSnap
    always_ff @(posedge clk) begin
      if (stb.snap) shadow[g] <= liveTime[g*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrByte && !pwrFail && !inTime) ram[ramIdx] <= stb.byteVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreWrEn   <= 1'b0;
      coreWrAddr <= '0;
      coreWrData <= '0;
    end else begin
      coreWrEn   <= stb.wrByte && !pwrFail && inTime;
      coreWrAddr <= ptr[T_W-1:0];
      coreWrData <= stb.byteVal;
    end
  end

endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
  import i2cs_pkg::*;
#(
  parameter int         SPACE      = 64,
  parameter int         TIME_REGS  = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'b1101000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  input  logic                         pwrFail,
  input  logic [TIME_REGS*8-1:0]       liveTime,
  output logic                         sdaOe,
  output logic                         coreWrEn,
  output logic [$clog2(TIME_REGS)-1:0] coreWrAddr,
  output logic [7:0]                   coreWrData
);

  strobe_t    stb;
  logic [7:0] rdByte;

  i2cs_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .pwrFail (pwrFail),
    .rdByte  (rdByte),
    .sdaOe   (sdaOe),
    .stb     (stb)
  );

  i2cs_data #(.SPACE(SPACE), .TIME_REGS(TIME_REGS)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .pwrFail    (pwrFail),
    .stb        (stb),
    .liveTime   (liveTime),
    .rdByte     (rdByte),
    .coreWrEn   (coreWrEn),
    .coreWrAddr (coreWrAddr),
    .coreWrData (coreWrData)
  );

endmodule

// File: rtl/rtc_bus_slave_chk.sv
module rtc_bus_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic pwrFail,
  input logic sdaOe,
  input logic coreWrEn
);

  // R10
  pwr_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> !sdaOe);

  // R10
  pwr_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> !coreWrEn);

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R3
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWrEn |=> !coreWrEn);

endmodule

bind rtc_bus_slave rtc_bus_slave_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .pwrFail  (pwrFail),
  .sdaOe    (sdaOe),
  .coreWrEn (coreWrEn)
);

// File: tb/rtc_bus_slave_test.sv
module rtc_bus_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic pwrFail = 1'b0;
  logic sdaLine;
  logic sdaOe, coreWrEn;
  logic [2:0] coreWrAddr;
  logic [7:0] coreWrData;
  logic [7:0] live [8];
  logic [63:0] liveVec;

  logic       pokeEn = 1'b0;
  int         pokeIdx = 0;
  logic [7:0] pokeVal = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mem [64];
  logic [7:0] snap [8];
  int mPtr = 0;
  int expQ [$];
  logic [7:0] wq [$];
  logic prevOe = 1'b0;

  assign sdaLine = mSda & ~sdaOe;

  always_comb begin
    for (int i = 0; i < 8; i++) liveVec[i*8 +: 8] = live[i];
  end

  rtc_bus_slave uut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (mScl),
    .sdaIn      (sdaLine),
    .pwrFail    (pwrFail),
    .liveTime   (liveVec),
    .sdaOe      (sdaOe),
    .coreWrEn   (coreWrEn),
    .coreWrAddr (coreWrAddr),
    .coreWrData (coreWrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clock-core model and per-clock comparison
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) live[i] = 8'h10 + 8'(i);
    end else begin
      if (pokeEn) live[pokeIdx] = pokeVal;
      if (coreWrEn) begin
        live[coreWrAddr] = coreWrData;
        if (expQ.size() == 0) check("R7 unexpected core write", {21'd0, coreWrAddr, coreWrData}, -1);
        else check("R7 core write", {21'd0, coreWrAddr, coreWrData}, expQ.pop_front());
      end
      if (mScl && sdaOe !== prevOe) check("R11 sdaOe moved with SCL high", sdaOe, prevOe);
    end
    prevOe = sdaOe;
  end

  task automatic poke(input int idx, input logic [7:0] val);
    pokeIdx = idx;
    pokeVal = val;
    @(posedge clk);
    pokeEn = 1'b1;
    @(posedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart;
    mSda = 1'b1; waitQ;
    mScl = 1'b1; waitQ;
    mSda = 1'b0; waitQ;
    mScl = 1'b0; waitQ;
  endtask

  task automatic busStop;
    mSda = 1'b0; waitQ;
    mScl = 1'b1; waitQ;
    mSda = 1'b1; waitQ;
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ;
    mScl = 1'b1; waitQ;
    waitQ;
    mScl = 1'b0; waitQ;
  endtask

  task automatic recvBit(output logic v);
    mSda = 1'b1; waitQ;
    mScl = 1'b1; waitQ;
    v = sdaLine; waitQ;
    mScl = 1'b0; waitQ;
  endtask

  task automatic writeByte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    recvBit(nak);
  endtask

  task automatic readByte(input logic nak, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recvBit(b[i]);
    sendBit(nak);
  endtask

  // write transfer: pointer then the bytes in wq
  task automatic writeRegs(input logic [7:0] ptr, input string req);
    logic nak;
    busStart;
    writeByte(8'hD0, nak);
    check({req, " address ack (R2)"}, nak, 0);
    writeByte(ptr, nak);
    check({req, " pointer ack"}, nak, 0);
    mPtr = int'(ptr) % 64;
    foreach (wq[k]) begin
      if (mPtr < 8) expQ.push_back(mPtr * 256 + int'(wq[k]));
      mem[mPtr] = wq[k];
      writeByte(wq[k], nak);
      check({req, " data ack"}, nak, 0);
      mPtr = (mPtr + 1) % 64;
    end
    busStop;
    waitQ;
    check({req, " pending core writes"}, expQ.size(), 0);
  endtask

  // read transfer; setPtr < 0 means no pointer write
  task automatic readRegs(input int setPtr, input int n, input int pokeAfter, input string req);
    logic nak;
    logic [7:0] b;
    int expv;
    busStart;
    if (setPtr >= 0) begin
      writeByte(8'hD0, nak);
      check({req, " write address ack"}, nak, 0);
      writeByte(8'(setPtr), nak);
      check({req, " pointer ack"}, nak, 0);
      mPtr = setPtr % 64;
      for (int i = 0; i < 8; i++) snap[i] = live[i];
      busStart;  // repeated START, R9
    end else begin
      for (int i = 0; i < 8; i++) snap[i] = live[i];
    end
    writeByte(8'hD1, nak);
    check({req, " read address ack (R2)"}, nak, 0);
    for (int k = 0; k < n; k++) begin
      readByte(k == n - 1, b);
      expv = (mPtr < 8) ? int'(snap[mPtr]) : int'(mem[mPtr]);
      check({req, " read data"}, b, expv);
      mPtr = (mPtr + 1) % 64;
      if (k == pokeAfter) poke(2, 8'h99);
    end
    waitQ;
    check({req, " released after NACK (R4)"}, sdaOe, 0);
    busStop;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before the test finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic nak;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 sdaOe after reset", sdaOe, 0);
    check("R1 coreWrEn after reset", coreWrEn, 0);

    // R3: RAM writes with increment
    wq = {8'h11, 8'h22, 8'h33, 8'h44};
    writeRegs(8'h10, "R3 RAM write");
    // R4 R9: pointer write, repeated START, read
    readRegs(8'h10, 3, -1, "R4 R9 read back");
    // R5: resume at retained pointer
    readRegs(-1, 1, -1, "R5 resume");

    // R7: writes spanning clock regs into RAM
    wq = {8'hA1, 8'hA2, 8'hA3};
    writeRegs(8'h06, "R7 span write");
    readRegs(8'h06, 3, -1, "R7 span read");

    // R8: snapshot held while live time changes mid-read
    readRegs(8'h00, 4, 1, "R8 snapshot");
    readRegs(8'h02, 1, -1, "R8 new START copy");

    // R6: wrap from 3Fh to 00h
    wq = {8'hC1, 8'hC2, 8'hC3};
    writeRegs(8'h3E, "R6 wrap write");
    readRegs(8'h3E, 3, -1, "R6 wrap read");

    // R3: upper pointer bits ignored
    readRegs(8'h52, 1, -1, "R3 pointer mask");

    // R2: foreign address ignored
    busStart;
    writeByte(8'hA2, nak);
    check("R2 foreign address nack", nak, 1);
    writeByte(8'h00, nak);
    check("R2 ignored byte nack", nak, 1);
    writeByte(8'h55, nak);
    check("R2 ignored byte nack", nak, 1);
    busStop;
    readRegs(-1, 1, -1, "R2 pointer untouched");

    // R10: power fail during a read and while traffic continues
    wq = {8'h5A};
    writeRegs(8'h30, "R10 setup");
    for (int i = 0; i < 8; i++) snap[i] = live[i];
    busStart;
    writeByte(8'hD1, nak);
    check("R10 read address ack", nak, 0);
    for (int i = 0; i < 3; i++) recvBit(b[i]);
    pwrFail = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 released on power fail", sdaOe, 0);
    busStop;
    busStart;
    writeByte(8'hD0, nak);
    check("R10 no ack during power fail", nak, 1);
    writeByte(8'h30, nak);
    check("R10 no ack during power fail", nak, 1);
    writeByte(8'hEE, nak);
    check("R10 no ack during power fail", nak, 1);
    writeByte(8'h01, nak);
    busStop;
    pwrFail = 1'b0;
    waitQ;
    mPtr = 0;
    readRegs(-1, 1, -1, "R10 pointer cleared");
    readRegs(8'h30, 1, -1, "R10 write ignored");
    check("R10 no core writes", expQ.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule